// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block carries out the two register-linked subroutine instructions of a 16-bit multicycle processor. It holds the eight-entry general register file, in which index 7 is the program counter and index 6 the stack pointer, and it drives a word-wide memory port. Elsewhere in the processor, the addressing logic has already resolved the call's destination specifier to an address. It has also advanced the program counter past the instruction and any extension word before the sequencer starts. The sequencer then performs the register and memory steps of the operation, one per cycle.

A call names a link register. The sequencer pushes that register onto the stack, copies the program counter into it, and jumps to the destination. A return reverses this: the link register goes to the program counter and the stacked word goes back into the link register. With the program counter as link, the pair reduces to an ordinary push-and-jump and pop-to-PC. With another register as link, the callee can walk in-line argument words through that register, and the return resumes after them. The rest of the processor loads and reads the registers through a write port and a read port. Every register write the sequencer makes is also visible on its outputs.

Top module: `subr_link_seq`

## Requirements
- R1: A call is decoded when instr[15:9] equals 7'b0000100. instr[8:6] selects the link register and instr[5:3] is the destination mode.
- R2: Call step one: the stack pointer R6 is decremented by 2. One memory write stores the link register's pre-call value at the new stack pointer address.
- R3: Call step two: the link register receives the program counter value held when the call started.
- R4: Call step three: the program counter R7 is loaded with dest_addr, which is sampled with start.
- R5: A return is decoded when instr[15:3] equals 13'b0000000010000, with the link register in instr[2:0].
- R6: Return: the program counter receives the link register's value. The word read from memory at the stack pointer goes into the link register, and the stack pointer increases by 2. No memory write occurs.
- R7: Link register R7: a call pushes the return address and jumps, and a return pops the stacked word into the program counter. With another link register, advancing that register during the subroutine moves the return point by the same amount.
- R8: A call whose destination mode is 0 raises trap for exactly one cycle, the cycle after start. It makes no register or memory write and never raises busy.
- R9: After an accepted start, busy is high for exactly three cycles and done is then high for exactly one cycle. A start that arrives while busy is high is ignored.
- R10: A start with any other instruction word, including 16'h0088 and 16'h0A00, causes no busy, done, trap, register change or memory write.
- R11: The external write port loads the addressed register at the clock edge. The read port returns any register combinationally, and all registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation in instr (one-cycle pulse) |
| instr | input | 16 | Instruction word |
| dest_addr | input | 16 | Resolved call destination address |
| ext_we | input | 1 | External register write enable |
| ext_waddr | input | 3 | External register write index |
| ext_wdata | input | 16 | External register write data |
| rd_sel | input | 3 | Register read index |
| rd_data | output | 16 | Register read data |
| mem_re | output | 1 | Memory read request; data is expected on mem_rdata the next cycle |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address (even) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| reg_we | output | 1 | Sequencer register write in this cycle |
| reg_waddr | output | 3 | Sequencer register write index |
| reg_wdata | output | 16 | Sequencer register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Illegal-call trap request pulse |

## Verification
The assertions check stack pointer steps, the saved link value and the program counter load after each step. They rely on the external write port staying idle while busy is high, because an outside write would otherwise change the registers between steps. They also rely on memory returning read data exactly one cycle after mem_re. The bench drives ext_we only while the sequencer is idle, and its memory model answers reads on the following clock edge.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;

   localparam int INSTR_W = 16;
   localparam int LINK_W  = 3;
   localparam int MODE_W  = 3;

   localparam logic [6:0]  CALL_OPC = 7'b0000100;
   localparam logic [12:0] RET_OPC  = 13'b0000000010000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_LINK,
      ST_JUMP,
      ST_PCLD,
      ST_POP,
      ST_RELINK,
      ST_DONE
   } seq_st_t;

   function automatic logic f_is_call(input logic [INSTR_W-1:0] w);
      return w[15:9] == CALL_OPC;
   endfunction

   function automatic logic f_is_ret(input logic [INSTR_W-1:0] w);
      return w[15:3] == RET_OPC;
   endfunction

   function automatic logic [MODE_W-1:0] f_mode(input logic [INSTR_W-1:0] w);
      return w[5:3];
   endfunction

endpackage

// File: rtl/sr_decode.sv
`timescale 1ns/1ps
module sr_decode
   import sr_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output logic               is_call,
   output logic               is_ret,
   output logic               call_bad,
   output logic [LINK_W-1:0]  link_sel
);

   logic call_hit;
   logic ret_hit;

   always_comb begin
      call_hit = f_is_call(instr);
      ret_hit  = f_is_ret(instr);
      is_call  = call_hit;
      is_ret   = ret_hit & ~call_hit;
      // register-mode destination has no address to jump to
      call_bad = call_hit & (f_mode(instr) == '0);
      if (call_hit) begin
         link_sel = instr[8:6];
      end else begin
         link_sel = instr[2:0];
      end
   end

endmodule

// File: rtl/sr_regfile.sv
`timescale 1ns/1ps
module sr_regfile #(
   parameter int DW        = 16,
   parameter int NREG      = 8,
   parameter int NRD       = 4,
   parameter bit CLEAR_RST = 1'b1,
   localparam int AW       = $clog2(NREG)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  a_we,
   input  logic [AW-1:0]         a_addr,
   input  logic [DW-1:0]         a_data,
   input  logic                  b_we,
   input  logic [AW-1:0]         b_addr,
   input  logic [DW-1:0]         b_data,
   input  logic [NRD-1:0][AW-1:0] rsel,
   output logic [NRD-1:0][DW-1:0] rdata
);

   if (NRD < 1) begin : g_bad_nrd
      $error("sr_regfile: NRD must be at least 1");
   end

   logic [NREG-1:0][DW-1:0] regs;
   logic                    w_en;
   logic [AW-1:0]           w_addr;
   logic [DW-1:0]           w_data;

   // port A (sequencer) has priority over port B (external)
   always_comb begin
      w_en   = a_we | b_we;
      w_addr = a_we ? a_addr : b_addr;
      w_data = a_we ? a_data : b_data;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (CLEAR_RST) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               regs[g] <= '0;
            end else if (w_en && (w_addr == AW'(g))) begin
               regs[g] <= w_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (w_en && (w_addr == AW'(g))) begin
               regs[g] <= w_data;
            end
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = regs[rsel[p]];
   end

endmodule

// File: rtl/sr_seq.sv
`timescale 1ns/1ps
module sr_seq
   import sr_pkg::*;
#(
   parameter int DW     = 16,
   parameter int AW     = 3,
   parameter int PC_IDX = 7,
   parameter int SP_IDX = 6,
   parameter int STEP   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_call,
   input  logic          is_ret,
   input  logic          call_bad,
   input  logic [AW-1:0] link_sel,
   input  logic [DW-1:0] dest_addr,
   input  logic [DW-1:0] link_val,
   input  logic [DW-1:0] sp_val,
   input  logic [DW-1:0] pc_val,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] link_q,
   output logic          reg_we,
   output logic [AW-1:0] reg_waddr,
   output logic [DW-1:0] reg_wdata,
   output logic          mem_re,
   output logic          mem_we,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          busy,
   output logic          done,
   output logic          trap
);

   localparam logic [AW-1:0] PC_A   = AW'(PC_IDX);
   localparam logic [AW-1:0] SP_A   = AW'(SP_IDX);
   localparam logic [DW-1:0] STEP_V = DW'(STEP);

   seq_st_t       st, st_nx;
   logic [DW-1:0] dest_q;
   logic [DW-1:0] tmp_q;
   logic          trap_q;
   logic          accept;
   logic [DW-1:0] sp_dec;
   logic [DW-1:0] sp_inc;

   assign accept = (st == ST_IDLE) && start;
   assign sp_dec = sp_val - STEP_V;
   assign sp_inc = sp_val + STEP_V;

   always_comb begin
      st_nx     = st;
      reg_we    = 1'b0;
      reg_waddr = PC_A;
      reg_wdata = '0;
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               if (is_call && !call_bad) begin
                  st_nx = ST_PUSH;
               end else if (is_ret) begin
                  st_nx = ST_PCLD;
               end
            end
         end
         ST_PUSH: begin
            reg_we    = 1'b1;
            reg_waddr = SP_A;
            reg_wdata = sp_dec;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = link_val;
            st_nx     = ST_LINK;
         end
         ST_LINK: begin
            reg_we    = 1'b1;
            reg_waddr = link_q;
            reg_wdata = pc_val;
            st_nx     = ST_JUMP;
         end
         ST_JUMP: begin
            reg_we    = 1'b1;
            reg_waddr = PC_A;
            reg_wdata = dest_q;
            st_nx     = ST_DONE;
         end
         ST_PCLD: begin
            reg_we    = 1'b1;
            reg_waddr = PC_A;
            reg_wdata = link_val;
            mem_re    = 1'b1;
            mem_addr  = sp_val;
            st_nx     = ST_POP;
         end
         ST_POP: begin
            reg_we    = 1'b1;
            reg_waddr = SP_A;
            reg_wdata = sp_inc;
            st_nx     = ST_RELINK;
         end
         ST_RELINK: begin
            reg_we    = 1'b1;
            reg_waddr = link_q;
            reg_wdata = tmp_q;
            st_nx     = ST_DONE;
         end
         ST_DONE: begin
            st_nx = ST_IDLE;
         end
         default: begin
            st_nx = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         link_q <= '0;
         dest_q <= '0;
         tmp_q  <= '0;
         trap_q <= 1'b0;
      end else begin
         st     <= st_nx;
         trap_q <= accept && is_call && call_bad;
         if (accept) begin
            link_q <= link_sel;
            dest_q <= dest_addr;
         end
         if (st == ST_POP) begin
            tmp_q <= mem_rdata;
         end
      end
   end

   assign busy = (st != ST_IDLE) && (st != ST_DONE);
   assign done = (st == ST_DONE);
   assign trap = trap_q;

   AST_SP_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PUSH) |=> (sp_val == $past(sp_val) - STEP_V)); // R2
   AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LINK) |=> (link_val == $past(pc_val))); // R3
   AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_JUMP) |=> (pc_val == $past(dest_q))); // R4
   AST_SP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POP) |=> (sp_val == $past(sp_val) + STEP_V)); // R6
   AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (!busy && !mem_we && !reg_we)); // R8
   AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> !trap); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy)); // R9

endmodule

// File: rtl/subr_link_seq.sv
`timescale 1ns/1ps
module subr_link_seq
   import sr_pkg::*;
#(
   parameter int DW        = 16,
   parameter int NREG      = 8,
   parameter int PC_IDX    = 7,
   parameter int SP_IDX    = 6,
   parameter int STEP      = 2,
   parameter bit CLEAR_RST = 1'b1,
   localparam int AW       = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [DW-1:0]       dest_addr,
   input  logic                ext_we,
   input  logic [AW-1:0]       ext_waddr,
   input  logic [DW-1:0]       ext_wdata,
   input  logic [AW-1:0]       rd_sel,
   output logic [DW-1:0]       rd_data,
   output logic                mem_re,
   output logic                mem_we,
   output logic [DW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   input  logic [DW-1:0]       mem_rdata,
   output logic                reg_we,
   output logic [AW-1:0]       reg_waddr,
   output logic [DW-1:0]       reg_wdata,
   output logic                busy,
   output logic                done,
   output logic                trap
);

   localparam int NRD   = 4;
   localparam int RP_EXT = 0;
   localparam int RP_LNK = 1;
   localparam int RP_SP  = 2;
   localparam int RP_PC  = 3;

   if (NREG != (1 << LINK_W)) begin : g_bad_nreg
      $error("subr_link_seq: NREG must match the 3-bit register field");
   end
   if (DW < 8) begin : g_bad_dw
      $error("subr_link_seq: DW must be at least 8");
   end
   if (PC_IDX >= NREG || SP_IDX >= NREG || PC_IDX == SP_IDX) begin : g_bad_idx
      $error("subr_link_seq: PC and SP indices must be distinct and in range");
   end
   if (STEP < 1) begin : g_bad_step
      $error("subr_link_seq: STEP must be positive");
   end

   logic                    is_call;
   logic                    is_ret;
   logic                    call_bad;
   logic [LINK_W-1:0]       link_sel;
   logic [AW-1:0]           link_q;
   logic [NRD-1:0][AW-1:0]  rsel;
   logic [NRD-1:0][DW-1:0]  rdata;

   sr_decode u_dec (
      .instr    (instr),
      .is_call  (is_call),
      .is_ret   (is_ret),
      .call_bad (call_bad),
      .link_sel (link_sel)
   );

   always_comb begin
      rsel[RP_EXT] = rd_sel;
      rsel[RP_LNK] = link_q;
      rsel[RP_SP]  = AW'(SP_IDX);
      rsel[RP_PC]  = AW'(PC_IDX);
   end

   sr_regfile #(
      .DW        (DW),
      .NREG      (NREG),
      .NRD       (NRD),
      .CLEAR_RST (CLEAR_RST)
   ) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_we   (reg_we),
      .a_addr (reg_waddr),
      .a_data (reg_wdata),
      .b_we   (ext_we),
      .b_addr (ext_waddr),
      .b_data (ext_wdata),
      .rsel   (rsel),
      .rdata  (rdata)
   );

   sr_seq #(
      .DW     (DW),
      .AW     (AW),
      .PC_IDX (PC_IDX),
      .SP_IDX (SP_IDX),
      .STEP   (STEP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_call   (is_call),
      .is_ret    (is_ret),
      .call_bad  (call_bad),
      .link_sel  (AW'(link_sel)),
      .dest_addr (dest_addr),
      .link_val  (rdata[RP_LNK]),
      .sp_val    (rdata[RP_SP]),
      .pc_val    (rdata[RP_PC]),
      .mem_rdata (mem_rdata),
      .link_q    (link_q),
      .reg_we    (reg_we),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .mem_re    (mem_re),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .busy      (busy),
      .done      (done),
      .trap      (trap)
   );

   assign rd_data = rdata[RP_EXT];

endmodule

// File: tb/test_subr_link_seq.sv
`timescale 1ns/1ps
module test_subr_link_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] dest_addr = '0;
   logic        ext_we = 1'b0;
   logic [2:0]  ext_waddr = '0;
   logic [15:0] ext_wdata = '0;
   logic [2:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        mem_re, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        reg_we;
   logic [2:0]  reg_waddr;
   logic [15:0] reg_wdata;
   logic        busy, done, trap;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [15:0] mem [64];

   always #2 clk = ~clk;

   subr_link_seq i_subr_link_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .dest_addr(dest_addr),
      .ext_we(ext_we), .ext_waddr(ext_waddr), .ext_wdata(ext_wdata),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .busy(busy), .done(done), .trap(trap)
   );

   // word memory: read data appears the cycle after the request
   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[6:1]] <= mem_wdata;
         wr_cnt = wr_cnt + 1;
      end
      if (mem_re) mem_rdata <= mem[mem_addr[6:1]];
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   typedef struct packed {
      logic [15:0] ins, dst, lnk, sp, pc, stk, e_pc, e_lnk, e_sp;
      logic        e_wr;
      logic [15:0] e_wa, e_wd;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VT [NV] = '{
      '{16'h09CB, 16'h0400, 16'h0204, 16'h0060, 16'h0204, 16'h0000, 16'h0400, 16'h0400, 16'h005E, 1'b1, 16'h005E, 16'h0204},
      '{16'h0971, 16'h0500, 16'h1234, 16'h0080, 16'h0302, 16'h0000, 16'h0500, 16'h0302, 16'h007E, 1'b1, 16'h007E, 16'h1234},
      '{16'h0087, 16'h0000, 16'h0100, 16'h0040, 16'h0100, 16'h0666, 16'h0666, 16'h0666, 16'h0042, 1'b0, 16'h0000, 16'h0000},
      '{16'h0085, 16'h0000, 16'h0308, 16'h0030, 16'h0510, 16'h4321, 16'h0308, 16'h4321, 16'h0032, 1'b0, 16'h0000, 16'h0000},
      '{16'h0813, 16'h0020, 16'hBEEF, 16'h0002, 16'h0010, 16'h0000, 16'h0020, 16'h0010, 16'h0000, 1'b1, 16'h0000, 16'hBEEF}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] idx, input logic [15:0] val);
      @(negedge clk);
      ext_we = 1'b1; ext_waddr = idx; ext_wdata = val;
      @(negedge clk);
      ext_we = 1'b0;
   endtask

   task automatic get_reg(input logic [2:0] idx, output logic [15:0] val);
      rd_sel = idx;
      #1;
      val = rd_data;
   endtask

   task automatic do_op(input logic [15:0] ins, input logic [15:0] dst,
                        output int nbusy, output int ndone, output int ntrap);
      @(negedge clk);
      start = 1'b1; instr = ins; dest_addr = dst;
      @(negedge clk);
      start = 1'b0;
      nbusy = 0; ndone = 0; ntrap = 0;
      for (int k = 0; k < 10; k++) begin
         if (busy) nbusy++;
         if (done) ndone++;
         if (trap) ntrap++;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [15:0] v;
      logic [2:0]  li;
      int nb, nd, nt, w0;

      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      chk("R11 busy after reset", 16'(busy), 16'h0);
      chk("R9 done after reset", 16'(done), 16'h0);
      chk("R8 trap after reset", 16'(trap), 16'h0);
      for (int r = 0; r < 8; r++) begin
         get_reg(3'(r), v);
         chk("R11 register cleared by reset", v, 16'h0);
      end
      wr_reg(3'd3, 16'hA5C3);
      get_reg(3'd3, v);
      chk("R11 external write readback", v, 16'hA5C3);

      // vector table: R1 R2 R3 R4 R5 R6 R7 R9
      for (int n = 0; n < NV; n++) begin
         li = (VT[n].ins[15:9] == 7'b0000100) ? VT[n].ins[8:6] : VT[n].ins[2:0];
         if (li < 3'd6) wr_reg(li, VT[n].lnk);
         wr_reg(3'd6, VT[n].sp);
         wr_reg(3'd7, VT[n].pc);
         mem[VT[n].sp[6:1]] = VT[n].stk;
         w0 = wr_cnt;
         do_op(VT[n].ins, VT[n].dst, nb, nd, nt);
         chk("R9 busy cycles", 16'(nb), 16'd3);
         chk("R9 done pulse width", 16'(nd), 16'd1);
         get_reg(3'd7, v);
         chk("R4/R6/R7 program counter", v, VT[n].e_pc);
         get_reg(li, v);
         chk("R3/R6 link register", v, VT[n].e_lnk);
         get_reg(3'd6, v);
         chk("R2/R6 stack pointer", v, VT[n].e_sp);
         chk("R2/R6 memory write count", 16'(wr_cnt - w0), 16'(VT[n].e_wr));
         if (VT[n].e_wr) chk("R2 pushed word", mem[VT[n].e_wa[6:1]], VT[n].e_wd);
      end

      // R7: in-line argument words through R5
      wr_reg(3'd5, 16'h1234);
      wr_reg(3'd6, 16'h0080);
      wr_reg(3'd7, 16'h0302);
      do_op(16'h0971, 16'h0500, nb, nd, nt);
      get_reg(3'd5, v);
      chk("R7 link holds argument pointer", v, 16'h0302);
      wr_reg(3'd5, v + 16'd4);
      do_op(16'h0085, 16'h0000, nb, nd, nt);
      get_reg(3'd7, v);
      chk("R7 return skips argument words", v, 16'h0306);
      get_reg(3'd5, v);
      chk("R7 link restored", v, 16'h1234);
      get_reg(3'd6, v);
      chk("R7 stack balanced", v, 16'h0080);

      // R8: register-mode destination
      wr_reg(3'd5, 16'h1111);
      wr_reg(3'd6, 16'h0060);
      wr_reg(3'd7, 16'h0200);
      w0 = wr_cnt;
      @(negedge clk);
      start = 1'b1; instr = 16'h0945; dest_addr = 16'h0700;
      @(negedge clk);
      start = 1'b0;
      chk("R8 trap raised", 16'(trap), 16'h1);
      chk("R8 busy stays low", 16'(busy), 16'h0);
      @(negedge clk);
      chk("R8 trap one cycle", 16'(trap), 16'h0);
      get_reg(3'd7, v); chk("R8 PC unchanged", v, 16'h0200);
      get_reg(3'd6, v); chk("R8 SP unchanged", v, 16'h0060);
      get_reg(3'd5, v); chk("R8 link unchanged", v, 16'h1111);
      chk("R8 no memory write", 16'(wr_cnt - w0), 16'h0);

      // R10: other instruction words
      do_op(16'h0088, 16'h0700, nb, nd, nt);
      chk("R10 0088 no busy", 16'(nb + nd + nt), 16'h0);
      do_op(16'h0A00, 16'h0700, nb, nd, nt);
      chk("R10 0A00 no busy", 16'(nb + nd + nt), 16'h0);
      get_reg(3'd7, v); chk("R10 PC unchanged", v, 16'h0200);
      get_reg(3'd6, v); chk("R10 SP unchanged", v, 16'h0060);
      chk("R10 no memory write", 16'(wr_cnt - w0), 16'h0);

      // R9: start while busy is ignored
      w0 = wr_cnt;
      @(negedge clk);
      start = 1'b1; instr = 16'h09CB; dest_addr = 16'h0400;
      @(negedge clk);
      instr = 16'h0971; dest_addr = 16'h0700;
      chk("R9 busy during call", 16'(busy), 16'h1);
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      get_reg(3'd7, v); chk("R9 second start ignored PC", v, 16'h0400);
      get_reg(3'd6, v); chk("R9 second start ignored SP", v, 16'h005E);
      chk("R9 single push", 16'(wr_cnt - w0), 16'h1);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule